// File: doc/BRIEF.md
# Non-volatile SRAM Mode Controller

This block sequences a memory built from a fast SRAM array and a shadow non-volatile array. In SRAM mode it passes host reads and writes to the array. It also gates the write strobe and the data output drive. A transfer has two directions. A STORE copies the SRAM into the non-volatile array. A RECALL first clears the SRAM and then copies the non-volatile contents back. While either transfer runs, the block hands the array one request strobe per phase and shuts out host access.

Several sources start a transfer. A STORE starts on a decoded software command, on assertion of an active-low hardware store pin, or on the supply dropping below its switch threshold. A software command can enable or disable the STORE on a falling supply. A RECALL starts on the end of power-on reset, on the supply recovering above the threshold, or on a software command. The block also tracks chip enable after power-up. It keeps a 24-bit record of the address of the last write that completed.

Top module: `nvsram_ctrl`

## Requirements
- R1: While `busy` is high, `sram_we` and `dq_oe` stay low whatever the host pins do.
- R2: In idle, any of the following starts a STORE: `sw_store`, a high-to-low transition of `hsb_n`, or a high-to-low transition of `vcc_above_sw` while power-fail store is enabled. The STORE starts with `arr_store` high from the next cycle until `arr_done` is sampled. A `hsb_n` that is held low does not retrigger.
- R3: In idle, any of the following starts a RECALL, with `arr_clear` high from the next cycle: the first cycle with `vcc_ok` high after it was low, a low-to-high transition of `vcc_above_sw`, or `sw_recall`.
- R4: A RECALL raises `arr_clear` until `arr_done`, then `arr_copy` until `arr_done`, then returns to idle. At most one of `arr_store`, `arr_clear` and `arr_copy` is high at a time.
- R5: Power-fail store is enabled out of reset. `sw_pf_off` disables it and `sw_pf_on` enables it. If both arrive together, disable wins. While it is disabled, a falling supply starts nothing.
- R6: While `vcc_ok` is low, all host and trigger inputs are ignored, `sram_we`, `dq_oe` and `busy` are low, and the chip-enable qualification is cleared.
- R7: After power-up, the host is not selected until `ce_n` has been sampled high with `vcc_ok` high. Any later low level of `ce_n` then selects the device.
- R8: `last_wr_addr` takes the zero-extended address of a write when `we_n` or `ce_n` ends that write in idle. A write that is cut off by a transfer start leaves it unchanged.
- R9: `busy` is low out of reset. It goes high in the cycle after a trigger is accepted and stays high until the final phase's `arr_done`.
- R10: Triggers and software commands that arrive while `busy` is high are ignored. They are not queued.
- R11: When a STORE trigger and a RECALL trigger fall in the same idle cycle, the STORE runs and the RECALL is dropped.
- R12: `dq_oe` is high exactly when the device is selected in idle with `we_n` high and `oe_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok | input | 1 | Supply stable at its minimum operating level |
| vcc_above_sw | input | 1 | Supply above the switch threshold |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| addr | input | ADDR_W | Host address |
| hsb_n | input | 1 | Hardware store request, active low |
| sw_store | input | 1 | Decoded software STORE command |
| sw_recall | input | 1 | Decoded software RECALL command |
| sw_pf_on | input | 1 | Decoded command enabling power-fail STORE |
| sw_pf_off | input | 1 | Decoded command disabling power-fail STORE |
| arr_done | input | 1 | Array reports the current phase finished |
| arr_store | output | 1 | Request to copy SRAM into the non-volatile array |
| arr_clear | output | 1 | Request to clear the SRAM (RECALL phase one) |
| arr_copy | output | 1 | Request to copy non-volatile data into SRAM (RECALL phase two) |
| busy | output | 1 | Transfer in progress |
| sram_sel | output | 1 | Host access selected |
| sram_we | output | 1 | Gated write strobe to the SRAM |
| dq_oe | output | 1 | Data output drive enable |
| last_wr_addr | output | LA_W | Address of the last completed write |

## Verification
The collision that matters is a STORE trigger and a RECALL trigger landing in the same idle cycle. The bench raises `sw_store` and `sw_recall` together. It then expects `arr_store` alone in the next cycle and an idle controller once that single phase has finished, with no RECALL left behind. A second coincidence is a host write that is still open when a hardware store is accepted. The bench opens a write, asserts `hsb_n` in the same cycle, and then checks that `sram_we` is cut off and that the recorded address still holds the previous completed write.

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int ADDR_W = 17,
  parameter int LA_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcc_ok,
  input  logic              vcc_above_sw,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hsb_n,
  input  logic              sw_store,
  input  logic              sw_recall,
  input  logic              sw_pf_on,
  input  logic              sw_pf_off,
  input  logic              arr_done,
  output logic              arr_store,
  output logic              arr_clear,
  output logic              arr_copy,
  output logic              busy,
  output logic              sram_sel,
  output logic              sram_we,
  output logic              dq_oe,
  output logic [LA_W-1:0]   last_wr_addr
);

  localparam int PAD_W = LA_W - ADDR_W;

  typedef enum logic [1:0] {T_IDLE, T_STORE, T_CLEAR, T_COPY} xfer_t;

  xfer_t             st;
  logic              vok_q, vsw_q, hsb_q, ce_armed, pf_en, wr_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic              idle, live, st_trig, rc_trig, wr_done;

  assign idle     = (st == T_IDLE);
  assign live     = vcc_ok && idle;
  assign busy     = !idle;
  assign arr_store = (st == T_STORE);
  assign arr_clear = (st == T_CLEAR);
  assign arr_copy  = (st == T_COPY);

  assign sram_sel = live && ce_armed && !ce_n;
  assign sram_we  = sram_sel && !we_n;
  assign dq_oe    = sram_sel && we_n && !oe_n;

  assign st_trig = live && (sw_store || (hsb_q && !hsb_n) ||
                            (pf_en && vsw_q && !vcc_above_sw));
  assign rc_trig = live && (sw_recall || !vok_q || (!vsw_q && vcc_above_sw));
  assign wr_done = live && wr_q && (we_n || ce_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vok_q <= 1'b0;
      vsw_q <= 1'b0;
      hsb_q <= 1'b1;
    end else begin
      vok_q <= vcc_ok;
      vsw_q <= vcc_above_sw;
      hsb_q <= hsb_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE;
    end else if (!vcc_ok) begin
      st <= T_IDLE;
    end else begin
      case (st)
        T_IDLE:  if (st_trig) st <= T_STORE;
                 else if (rc_trig) st <= T_CLEAR;
        T_STORE: if (arr_done) st <= T_IDLE;
        T_CLEAR: if (arr_done) st <= T_COPY;
        default: if (arr_done) st <= T_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_armed <= 1'b0;
      pf_en    <= 1'b1;
    end else if (!vcc_ok) begin
      ce_armed <= 1'b0;
    end else begin
      if (ce_n) ce_armed <= 1'b1;
      if (idle) begin
        if (sw_pf_off)     pf_en <= 1'b0;
        else if (sw_pf_on) pf_en <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q         <= 1'b0;
      wr_addr_q    <= '0;
      last_wr_addr <= '0;
    end else begin
      wr_q <= sram_we;
      if (sram_we) wr_addr_q <= addr;
      if (wr_done) last_wr_addr <= {{PAD_W{1'b0}}, wr_addr_q};
    end
  end

  AST_NO_IO_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sram_we && !dq_oe); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_store, arr_clear, arr_copy})); // R4
  AST_CLEAR_THEN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_ok && arr_clear && arr_done |=> arr_copy); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_ok && busy && !arr_done |=> busy); // R9
  AST_POR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |-> !sram_we && !dq_oe); // R6
  AST_STORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_ok && !busy && sw_store |=> arr_store); // R11
  AST_BUSY_BLOCKS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(last_wr_addr)); // R8

endmodule

// File: tb/sim_nvsram_ctrl.sv
`timescale 1ns/1ps
module sim_nvsram_ctrl;
  localparam int AW = 17;
  localparam int LW = 24;

  logic clk = 1'b0;
  logic rst_n, vcc_ok, vsw, ce_n, we_n, oe_n, hsb_n;
  logic sw_store, sw_recall, sw_pf_on, sw_pf_off, arr_done;
  logic [AW-1:0] addr;
  logic arr_store, arr_clear, arr_copy, busy, sram_sel, sram_we, dq_oe;
  logic [LW-1:0] last_wr_addr;
  int runs = 0, fails = 0;
  logic [LW-1:0] exp_last;

  always #2.5 clk = ~clk;

  nvsram_ctrl #(.ADDR_W(AW), .LA_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_above_sw(vsw),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .hsb_n(hsb_n),
    .sw_store(sw_store), .sw_recall(sw_recall), .sw_pf_on(sw_pf_on),
    .sw_pf_off(sw_pf_off), .arr_done(arr_done), .arr_store(arr_store),
    .arr_clear(arr_clear), .arr_copy(arr_copy), .busy(busy),
    .sram_sel(sram_sel), .sram_we(sram_we), .dq_oe(dq_oe),
    .last_wr_addr(last_wr_addr));

  function automatic logic [LW-1:0] ext(input logic [AW-1:0] a);
    return {{(LW-AW){1'b0}}, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic done_pulse();
    arr_done = 1'b1; step(1); arr_done = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a);
    addr = a; ce_n = 1'b0; we_n = 1'b0; step(1);
    we_n = 1'b1; ce_n = 1'b1; step(1);
    exp_last = ext(a);
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; vcc_ok = 0; vsw = 0; ce_n = 0; we_n = 0; oe_n = 0; hsb_n = 1;
    sw_store = 0; sw_recall = 0; sw_pf_on = 0; sw_pf_off = 0; arr_done = 0;
    addr = '0; exp_last = '0;
    step(2); rst_n = 1; step(2);
    chk("R9 reset busy", busy, 0);
    chk("R6 por no write", sram_we, 0);
    chk("R6 por no drive", dq_oe, 0);
    chk("R8 reset addr", last_wr_addr, 0);

    vcc_ok = 1; vsw = 1; step(1);
    chk("R3 powerup recall clear", arr_clear, 1);
    chk("R9 busy on accept", busy, 1);
    step(3);
    chk("R4 clear holds", {arr_clear, arr_copy}, 2'b10);
    done_pulse();
    chk("R4 copy phase", {arr_clear, arr_copy}, 2'b01);
    done_pulse();
    chk("R9 busy released", busy, 0);
    chk("R7 not armed", sram_we, 0);
    ce_n = 1; we_n = 1; step(1);
    do_write(17'h1abcd);
    chk("R8 write logged", last_wr_addr, exp_last);
    ce_n = 0; oe_n = 0; #1;
    chk("R12 read drives", dq_oe, 1);
    chk("R7 selected after high", sram_sel, 1);
    oe_n = 1; #1;
    chk("R12 oe high no drive", dq_oe, 0);
    ce_n = 1; step(1);

    addr = 17'h00555; ce_n = 0; we_n = 0; hsb_n = 0; step(1);
    chk("R2 hsb store", arr_store, 1);
    chk("R1 write gated", sram_we, 0);
    sw_recall = 1; sw_pf_off = 1; step(1); sw_recall = 0; sw_pf_off = 0;
    ce_n = 1; we_n = 1; step(1);
    done_pulse(); step(2);
    chk("R10 recall not queued", busy, 0);
    chk("R2 held hsb no retrigger", arr_store, 0);
    chk("R8 cut write not logged", last_wr_addr, exp_last);
    hsb_n = 1; step(1);

    vsw = 0; step(1);
    chk("R5 pf store on by default (R10 off ignored)", arr_store, 1);
    done_pulse();
    vsw = 1; step(1);
    chk("R3 supply rise recall", arr_clear, 1);
    done_pulse(); done_pulse();

    sw_pf_off = 1; sw_pf_on = 1; step(1); sw_pf_off = 0; sw_pf_on = 0;
    vsw = 0; step(1);
    chk("R5 disabled no store", busy, 0);
    vsw = 1; step(1); done_pulse(); done_pulse();
    sw_pf_on = 1; step(1); sw_pf_on = 0;
    vsw = 0; step(1);
    chk("R5 reenabled store", arr_store, 1);
    done_pulse();
    vsw = 1; step(1); done_pulse(); done_pulse();

    sw_store = 1; sw_recall = 1; step(1); sw_store = 0; sw_recall = 0;
    chk("R11 store wins", {arr_store, arr_clear}, 2'b10);
    done_pulse(); step(1);
    chk("R11 recall dropped", busy, 0);
    sw_recall = 1; step(1); sw_recall = 0;
    chk("R3 sw recall", arr_clear, 1);
    done_pulse(); done_pulse();
    sw_store = 1; step(1); sw_store = 0;
    chk("R2 sw store", arr_store, 1);
    done_pulse();

    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom % 4;
      if (op < 2) begin
        do_write(AW'($urandom));
        chk("R8 random write", last_wr_addr, exp_last);
      end else if (op == 2) begin
        ce_n = 0; we_n = 1; oe_n = $urandom % 2; #1;
        chk("R12 random read", dq_oe, !oe_n);
        ce_n = 1; oe_n = 1; step(1);
      end else begin
        sw_store = 1; ce_n = 0; we_n = 0; addr = AW'($urandom); step(1);
        sw_store = 0;
        chk("R1 random busy gate", sram_we, 0);
        ce_n = 1; we_n = 1;
        step($urandom % 4); done_pulse();
        chk("R8 random store kept", last_wr_addr, exp_last);
      end
    end

    vcc_ok = 0; ce_n = 0; we_n = 0; step(1);
    chk("R6 por gate write", sram_we, 0);
    chk("R6 por not busy", busy, 0);
    vcc_ok = 1; step(1);
    chk("R3 second powerup recall", arr_clear, 1);
    we_n = 1; done_pulse(); done_pulse();
    chk("R7 disarmed after por", sram_sel, 0);
    finish_tb();
  end
endmodule